// File: doc/BRIEF.md
# Power-Up Reset Sequencer

This block releases a multi-domain chip from reset at power-up in a fixed order. It watches five qualifiers that arrive asynchronously from the platform and the clocking logic:

- regulator power-good
- reference clock stable
- PLL lock
- system power-OK
- I/O and core clocks stable

It acts on each qualifier only after the one before it has passed. Once the clocks are stable, it releases the platform reset, which frees every domain except the processor core. After a programmable gap it releases the core reset.

Each qualifier goes through a two-flop synchronizer. It must then stay high for a programmable number of consecutive cycles before the sequencer advances. If any qualifier that has already passed drops, the sequencer returns to full reset.

Two static select buses, bus speed and core voltage, are driven from power-on. A state output exposes the current step.

Top module: `pwrup_rst_seq`

## Requirements
- R1: While `por_n` is low, and in the first cycle after it rises, `plat_rst_n`, `core_rst_n` and `pwr_good` are 0 and `seq_state` is 0. Pulling `por_n` low at any time forces these values at once.
- R2: `spd_sel` always equals parameter `SPD_SEL` and `volt_sel` always equals parameter `VOLT_SEL`, including while `por_n` is low.
- R3: The qualifiers are honoured strictly in this order: regulator good, reference clock, PLL lock, system power-OK, clocks stable. A later qualifier that is high before its turn does not advance the state.
- R4: Each qualifier passes through a two-flop synchronizer and must read high for `DEB_CYC` consecutive cycles. A qualifier that rises at a falling clock edge moves `seq_state` on at the (`DEB_CYC`+2)-th following rising edge. A shorter high pulse is ignored.
- R5: `pwr_good` goes to 1 when system power-OK passes, while both resets stay low.
- R6: When clocks-stable passes, `plat_rst_n` goes to 1 and `core_rst_n` stays 0.
- R7: `core_rst_n` rises exactly `GAP_CYC` cycles after `plat_rst_n` rises. `core_rst_n` is never 1 while `plat_rst_n` is 0.
- R8: If a qualifier that has already passed reads low after synchronization, `seq_state` returns to 0 at the next edge, and both resets and `pwr_good` drop with it. A qualifier that falls at a falling clock edge shows this at the third rising edge that follows.
- R9: `seq_state` uses these codes:
  - 0: wait for regulator good
  - 1: wait for reference clock
  - 2: wait for PLL lock
  - 3: wait for system power-OK
  - 4: wait for clocks stable
  - 5: platform released, gap running
  - 6: core released

  From any state it moves only to the next code or to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sequencer clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| vreg_good_a | input | 1 | Regulator power-good, asynchronous |
| refclk_ok_a | input | 1 | Reference clock stable, asynchronous |
| pll_lock_a | input | 1 | Clock-unit PLL locked, asynchronous |
| sys_pwr_ok_a | input | 1 | System power-OK, asynchronous |
| clks_stable_a | input | 1 | I/O and core clocks stable, asynchronous |
| spd_sel | output | SPD_W | Static bus-speed select |
| volt_sel | output | VOLT_W | Static voltage select |
| pwr_good | output | 1 | Internal power-good |
| plat_rst_n | output | 1 | Platform reset, active low |
| core_rst_n | output | 1 | Core reset, active low |
| seq_state | output | 3 | Current sequencer state code |

## Verification
The bench builds the block with `DEB_CYC` = 4 and `GAP_CYC` = 6. These small values let it place every edge exactly within a few cycles:

- It can check the last cycle before each advance and the cycle of the advance itself.
- It can show that a pulse one cycle shorter than the debounce window is ignored.
- It can count the full release gap between the two resets.

At the same time the windows are long enough to keep the debounce and the gap distinct from the two synchronizer stages.

// File: rtl/pwrup_rst_seq.sv
module pwrup_rst_seq #(
  parameter int SPD_W = 3,
  parameter int VOLT_W = 6,
  parameter logic [SPD_W-1:0] SPD_SEL = 3'b010,
  parameter logic [VOLT_W-1:0] VOLT_SEL = 6'h23,
  parameter int DEB_CYC = 16,
  parameter int GAP_CYC = 64
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              vreg_good_a,
  input  logic              refclk_ok_a,
  input  logic              pll_lock_a,
  input  logic              sys_pwr_ok_a,
  input  logic              clks_stable_a,
  output logic [SPD_W-1:0]  spd_sel,
  output logic [VOLT_W-1:0] volt_sel,
  output logic              pwr_good,
  output logic              plat_rst_n,
  output logic              core_rst_n,
  output logic [2:0]        seq_state
);
  localparam int NQ = 5;
  localparam int CNT_MAX = (DEB_CYC > GAP_CYC) ? DEB_CYC : GAP_CYC;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [2:0] ST_FULL = 3'd0;
  localparam logic [2:0] ST_PWRG = 3'd4;
  localparam logic [2:0] ST_GAP  = 3'd5;
  localparam logic [2:0] ST_RUN  = 3'd6;

  assign spd_sel  = SPD_SEL;
  assign volt_sel = VOLT_SEL;

  logic [NQ-1:0] q_m, q_s;
  logic [2:0]    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [NQ-1:0] need;
  logic          cur, fault;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      q_m <= '0;
      q_s <= '0;
    end else begin
      q_m <= {clks_stable_a, sys_pwr_ok_a, pll_lock_a, refclk_ok_a, vreg_good_a};
      q_s <= q_m;
    end

  always_comb
    for (int i = 0; i < NQ; i++)
      need[i] = (st_q > 3'(i));

  assign fault = |(need & ~q_s);
  assign cur   = (st_q < 3'(NQ)) ? q_s[st_q] : 1'b0;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (fault) begin
      st_d  = ST_FULL;
      cnt_d = '0;
    end else if (st_q < 3'(NQ)) begin
      if (!cur)
        cnt_d = '0;
      else if (cnt_q == CW'(DEB_CYC - 1)) begin
        st_d  = st_q + 3'd1;
        cnt_d = '0;
      end else
        cnt_d = cnt_q + 1'b1;
    end else if (st_q == ST_GAP) begin
      if (cnt_q == CW'(GAP_CYC - 1)) begin
        st_d  = ST_RUN;
        cnt_d = '0;
      end else
        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      st_q       <= ST_FULL;
      cnt_q      <= '0;
      pwr_good   <= 1'b0;
      plat_rst_n <= 1'b0;
      core_rst_n <= 1'b0;
    end else begin
      st_q       <= st_d;
      cnt_q      <= cnt_d;
      pwr_good   <= (st_d >= ST_PWRG);
      plat_rst_n <= (st_d >= ST_GAP);
      core_rst_n <= (st_d == ST_RUN);
    end

  assign seq_state = st_q;
endmodule

module pwrup_rst_seq_chk (
  input logic       clk,
  input logic       por_n,
  input logic [2:0] st,
  input logic [4:0] qs,
  input logic       plat,
  input logic       core,
  input logic       good
);
  a_r7_core_after_plat: assert property (@(posedge clk) disable iff (!por_n)
    core |-> plat);
  a_r5_good_before_plat: assert property (@(posedge clk) disable iff (!por_n)
    plat |-> good);
  a_r9_state_legal: assert property (@(posedge clk) disable iff (!por_n)
    st <= 3'd6);
  a_r9_single_step: assert property (@(posedge clk) disable iff (!por_n)
    (st != $past(st)) |-> (st == 3'd0 || st == $past(st) + 3'd1));
  a_r8_drop_to_full: assert property (@(posedge clk) disable iff (!por_n)
    (st != 3'd0 && !qs[0]) |=> (st == 3'd0 && !plat && !core));
  a_r6_plat_with_state: assert property (@(posedge clk) disable iff (!por_n)
    plat == (st >= 3'd5));
endmodule

bind pwrup_rst_seq pwrup_rst_seq_chk u_chk (
  .clk(clk), .por_n(por_n), .st(st_q), .qs(q_s),
  .plat(plat_rst_n), .core(core_rst_n), .good(pwr_good)
);

// File: tb/sim_pwrup_rst_seq.sv
module sim_pwrup_rst_seq;
  localparam int DEB = 4;
  localparam int GAP = 6;
  localparam logic [2:0] SPD = 3'b101;
  localparam logic [5:0] VLT = 6'h2c;

  logic clk = 0, por_n = 0;
  logic [4:0] q = '0;
  logic [2:0] spd_sel;
  logic [5:0] volt_sel;
  logic pwr_good, plat_rst_n, core_rst_n;
  logic [2:0] seq_state;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  pwrup_rst_seq #(.SPD_W(3), .VOLT_W(6), .SPD_SEL(SPD), .VOLT_SEL(VLT),
                  .DEB_CYC(DEB), .GAP_CYC(GAP)) u0 (
    .clk(clk), .por_n(por_n),
    .vreg_good_a(q[0]), .refclk_ok_a(q[1]), .pll_lock_a(q[2]),
    .sys_pwr_ok_a(q[3]), .clks_stable_a(q[4]),
    .spd_sel(spd_sel), .volt_sel(volt_sel), .pwr_good(pwr_good),
    .plat_rst_n(plat_rst_n), .core_rst_n(core_rst_n), .seq_state(seq_state));

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic outs(string req, int st, bit g, bit p, bit c);
    chk(req, seq_state, st);
    chk(req, pwr_good, g);
    chk(req, plat_rst_n, p);
    chk(req, core_rst_n, c);
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic step(int idx, int exp);
    q[idx] = 1'b1;
    repeat (DEB + 1) @(posedge clk);
    @(negedge clk);
    chk("R4 not yet", seq_state, exp - 1);
    cyc(1);
    chk("R4 advance", seq_state, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    outs("R1 in reset", 0, 0, 0, 0);
    chk("R2 spd in reset", spd_sel, SPD);
    chk("R2 volt in reset", volt_sel, VLT);
    por_n = 1'b1;
    cyc(1);
    outs("R1 after reset", 0, 0, 0, 0);
  endtask

  task automatic t_order;
    q = 5'b11110;
    cyc(20);
    chk("R3 later qualifiers ignored", seq_state, 0);
    q = '0;
    cyc(4);
  endtask

  task automatic t_glitch;
    q[0] = 1'b1;
    cyc(DEB - 1);
    q[0] = 1'b0;
    cyc(12);
    chk("R4 short pulse ignored", seq_state, 0);
  endtask

  task automatic t_bringup;
    int n;
    step(0, 1);
    step(1, 2);
    step(2, 3);
    outs("R5 before sysok", 3, 0, 0, 0);
    step(3, 4);
    outs("R5 power good", 4, 1, 0, 0);
    step(4, 5);
    outs("R6 platform released", 5, 1, 1, 0);
    n = 0;
    for (int k = 0; k < 50; k++) begin
      cyc(1);
      n++;
      if (core_rst_n) break;
    end
    chk("R7 gap length", n, GAP);
    outs("R9 running code", 6, 1, 1, 1);
    chk("R2 spd running", spd_sel, SPD);
  endtask

  task automatic t_fault;
    q[2] = 1'b0;
    cyc(2);
    outs("R8 before sync", 6, 1, 1, 1);
    cyc(1);
    outs("R8 dropped to full", 0, 0, 0, 0);
    cyc(3 * DEB + 6);
    chk("R3 restart stalls at pll", seq_state, 2);
    chk("R8 plat held", plat_rst_n, 0);
    q[2] = 1'b1;
    cyc(3 * DEB + GAP + 10);
    outs("R9 back to running", 6, 1, 1, 1);
  endtask

  task automatic t_por;
    #1 por_n = 1'b0;
    #1;
    outs("R1 async por", 0, 0, 0, 0);
    chk("R2 volt under por", volt_sel, VLT);
    q = '0;
    cyc(2);
    por_n = 1'b1;
    cyc(2);
    outs("R1 por release", 0, 0, 0, 0);
  endtask

  initial begin
    t_reset;
    t_order;
    t_glitch;
    t_bringup;
    t_fault;
    t_por;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule